// File: doc/BRIEF.md
# MDIO Management Master with Register Access

This block is a management-bus master for clause 22 PHY register access. Software programs a control word with a run enable and a clock divisor. It then writes an access word that carries a start flag, a direction, the PHY and register addresses and, for writes, the data. The engine derives the management clock from the system clock and shifts a 64-bit frame onto a tri-stated data line. On reads it releases the line from the turnaround onward and captures the acknowledge and the returned data.

Completion is reported by the start flag clearing itself. After a read, the acknowledge flag in the same word tells software whether the data field is valid. Clearing the enable stops an active frame without losing the pending request. The frame restarts from its preamble once the enable returns.

Top module: `mdio_user_engine`

## Requirements
- R1: After reset the access word reads 0, the control word reads 0x8000_0000 (idle 1, enable 0, divisor 0), and `mdc` and `mdio_oe` are low.
- R2: While a frame runs, the `mdc` period is divisor+1 system clocks, and `mdc` is high for floor((divisor+1)/2) of them. A divisor of 0 behaves as 1.
- R3: Each frame is 64 `mdc` periods, MSB first, one bit per period, changed after the falling edge and stable at the rising edge. Bits 0-31 are ones, bits 32-33 are 01, bits 34-35 are the opcode (read 10, write 01), bits 36-40 are the PHY address and bits 41-45 are the register address.
- R4: A write frame sends 10 in bits 46-47 and the 16 data bits in bits 48-63. `mdio_oe` is high for all 64 bits.
- R5: A read frame drops `mdio_oe` from bit 46 through the end. The acknowledge flag is set only if `mdio_i` is low at the rising edge of bit 47. The data captured at the rising edges of bits 48-63 lands MSB first in access bits 15:0.
- R6: Access word layout: go at bit 31, write at 30, acknowledge at 29, register address at 25:21, PHY address at 20:16, data at 15:0. Control word layout: idle at 31, enable at 30, divisor at 15:0. Go stays 1 from acceptance to frame end and then clears, and idle reads 0 while a frame runs.
- R7: A write to the access word while go is 1 is ignored: no field changes and no extra frame follows.
- R8: An access write with go 0 stores the fields, reads them back with acknowledge 0, and starts no frame.
- R9: Go written while enable is 0 stays pending with `mdc` idle low. The frame starts once enable is set.
- R10: Clearing enable during a frame stops it within two clocks: idle reads 1, and `mdc` and `mdio_oe` are low. Go stays 1, and re-enabling reruns the whole frame from the preamble.
- R11: The acknowledge flag is cleared when an access word is accepted, and a write frame leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_sel | input | 1 | 0 selects the control word, 1 the access word |
| reg_wdata | input | 32 | Register write data |
| ctrl_rdata | output | 32 | Control word readback with idle status |
| acc_rdata | output | 32 | Access word readback |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input (pulled high when undriven) |

## Verification
The properties take for granted that the divisor is rewritten only while no frame is running, and that register writes are single-cycle strobes. The scoreboard and the PHY model additionally assume that `mdio_i` is driven by the far end only in the bit periods the master has released. The bench changes the divisor only between frames and always waits for go to clear before issuing a new request. The exception is the deliberate overlapping write that tests the ignore rule. Its bus-side PHY model drives the data line only after a falling `mdc` edge in the read turnaround and data bits. It returns to a pulled-up line whenever the engine reports idle.

// File: rtl/mdio_ue_pkg.sv
package mdio_ue_pkg;

   localparam int ACC_GO     = 31;
   localparam int ACC_WRITE  = 30;
   localparam int ACC_ACK    = 29;
   localparam int ACC_REG_LO = 21;
   localparam int ACC_PHY_LO = 16;
   localparam int CTL_IDLE   = 31;
   localparam int CTL_EN     = 30;

   localparam int ADDR_W = 5;
   localparam int DATA_W = 16;

   localparam logic [1:0] START_CODE = 2'b01;
   localparam logic [1:0] OP_READ    = 2'b10;
   localparam logic [1:0] OP_WRITE   = 2'b01;
   localparam logic [1:0] TA_WRITE   = 2'b10;
   localparam logic [1:0] TA_READ    = 2'b11;

   typedef struct packed {
      logic              wr;
      logic [ADDR_W-1:0] phy;
      logic [ADDR_W-1:0] regad;
      logic [DATA_W-1:0] data;
   } mdio_req_t;

endpackage

// File: rtl/mdio_ue_clkgen.sv
module mdio_ue_clkgen #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             mdc,
   output logic             rise_evt,
   output logic             fall_evt
);

   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

   logic [DIV_W-1:0] div_eff;
   logic [DIV_W:0]   period;
   logic [DIV_W-1:0] half;
   logic [DIV_W-1:0] cnt;

   // a divisor of zero cannot produce a registered clock; treat it as one
   assign div_eff  = (div == '0) ? ONE : div;
   assign period   = {1'b0, div_eff} + (DIV_W+1)'(1);
   assign half     = period[DIV_W:1];
   assign rise_evt = run && (cnt == div_eff);
   assign fall_evt = run && (cnt == half - ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (!run) begin
         cnt <= half;
         mdc <= 1'b0;
      end else if (rise_evt) begin
         cnt <= '0;
         mdc <= 1'b1;
      end else begin
         cnt <= cnt + ONE;
         if (fall_evt) mdc <= 1'b0;
      end
   end

   AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_evt && fall_evt)); // R2

   AST_RISE_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      rise_evt |-> !mdc); // R2

endmodule

// File: rtl/mdio_ue_shifter.sv
module mdio_ue_shifter
   import mdio_ue_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              start,
   input  mdio_req_t         req,
   input  logic              rise_evt,
   input  logic              fall_evt,
   input  logic              mdio_i,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic              busy,
   output logic              done,
   output logic              ack,
   output logic [DATA_W-1:0] rdata
);

   localparam int FRAME_LEN = PRE_LEN + 32;
   localparam int CNT_W     = $clog2(FRAME_LEN);
   localparam int TA_IDX    = PRE_LEN + 14;
   localparam int ACK_IDX   = TA_IDX + 1;
   localparam int DATA_IDX  = PRE_LEN + 16;
   localparam int LAST_IDX  = FRAME_LEN - 1;

   localparam logic [CNT_W-1:0] C_TA   = CNT_W'(TA_IDX);
   localparam logic [CNT_W-1:0] C_ACK  = CNT_W'(ACK_IDX);
   localparam logic [CNT_W-1:0] C_DATA = CNT_W'(DATA_IDX);
   localparam logic [CNT_W-1:0] C_LAST = CNT_W'(LAST_IDX);
   localparam logic [CNT_W-1:0] C_ONE  = CNT_W'(1);

   logic [FRAME_LEN-1:0] sr;
   logic [FRAME_LEN-1:0] frame_w;
   logic [CNT_W-1:0]     bitcnt;
   logic [CNT_W-1:0]     bit_nxt;
   logic                 is_wr;
   logic [DATA_W-1:0]    rd_sr;
   logic [PRE_LEN-1:0]   preamble;

   generate
      for (genvar gi = 0; gi < PRE_LEN; gi++) begin : g_pre
         assign preamble[gi] = 1'b1;
      end
   endgenerate

   assign frame_w = {preamble, START_CODE,
                     req.wr ? OP_WRITE : OP_READ,
                     req.phy, req.regad,
                     req.wr ? TA_WRITE : TA_READ,
                     req.wr ? req.data : {DATA_W{1'b1}}};

   assign bit_nxt = bitcnt + C_ONE;
   assign mdio_o  = busy & sr[FRAME_LEN-1];
   assign done    = busy && en && fall_evt && (bitcnt == C_LAST);
   assign rdata   = rd_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         sr      <= '0;
         bitcnt  <= '0;
         is_wr   <= 1'b0;
         mdio_oe <= 1'b0;
         ack     <= 1'b0;
         rd_sr   <= '0;
      end else if (!en) begin
         busy    <= 1'b0;
         mdio_oe <= 1'b0;
      end else if (start && !busy) begin
         busy    <= 1'b1;
         sr      <= frame_w;
         bitcnt  <= '0;
         is_wr   <= req.wr;
         mdio_oe <= 1'b1;
         ack     <= 1'b0;
      end else if (busy) begin
         if (fall_evt) begin
            if (bitcnt == C_LAST) begin
               busy    <= 1'b0;
               mdio_oe <= 1'b0;
            end else begin
               sr      <= {sr[FRAME_LEN-2:0], 1'b1};
               bitcnt  <= bit_nxt;
               mdio_oe <= is_wr || (bit_nxt < C_TA);
            end
         end
         if (rise_evt && !is_wr) begin
            if (bitcnt == C_ACK) ack <= !mdio_i;
            if (bitcnt >= C_DATA) rd_sr <= {rd_sr[DATA_W-2:0], mdio_i};
         end
      end
   end

   AST_READ_RELEASES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !is_wr && bitcnt >= C_TA) |-> !mdio_oe); // R5

   AST_WRITE_DRIVES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && is_wr) |-> mdio_oe); // R4

   AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdio_oe); // R10

endmodule

// File: rtl/mdio_user_engine.sv
module mdio_user_engine
   import mdio_ue_pkg::*;
#(
   parameter int DIV_W   = 16,
   parameter int PRE_LEN = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_sel,
   input  logic [31:0] reg_wdata,
   output logic [31:0] ctrl_rdata,
   output logic [31:0] acc_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);

   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("DIV_W must lie in 1..16");
      end
      if (PRE_LEN < 1 || PRE_LEN > 32) begin : g_bad_pre
         $error("PRE_LEN must lie in 1..32");
      end
   endgenerate

   logic             en_q;
   logic [DIV_W-1:0] div_q;
   logic             go_q;
   logic             ack_q;
   mdio_req_t        req_q;

   logic              start;
   logic              sh_busy;
   logic              sh_done;
   logic              sh_ack;
   logic [DATA_W-1:0] sh_rdata;
   logic              rise_evt;
   logic              fall_evt;
   logic              ctl_wr;
   logic              acc_wr;

   assign ctl_wr = reg_wr && !reg_sel;
   assign acc_wr = reg_wr &&  reg_sel;
   assign start  = go_q && en_q && !sh_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         div_q <= '0;
      end else if (ctl_wr) begin
         en_q  <= reg_wdata[CTL_EN];
         div_q <= reg_wdata[DIV_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         go_q  <= 1'b0;
         ack_q <= 1'b0;
         req_q <= '0;
      end else if (acc_wr && !go_q) begin
         go_q        <= reg_wdata[ACC_GO];
         ack_q       <= 1'b0;
         req_q.wr    <= reg_wdata[ACC_WRITE];
         req_q.regad <= reg_wdata[ACC_REG_LO +: ADDR_W];
         req_q.phy   <= reg_wdata[ACC_PHY_LO +: ADDR_W];
         req_q.data  <= reg_wdata[DATA_W-1:0];
      end else if (sh_done) begin
         go_q <= 1'b0;
         if (!req_q.wr) begin
            req_q.data <= sh_rdata;
            ack_q      <= sh_ack;
         end
      end
   end

   assign ctrl_rdata = {!sh_busy, en_q, 14'd0, 16'(div_q)};
   assign acc_rdata  = {go_q, req_q.wr, ack_q, 3'd0, req_q.regad, req_q.phy, req_q.data};

   mdio_ue_clkgen #(.DIV_W(DIV_W)) u_clkgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (sh_busy && en_q),
      .div      (div_q),
      .mdc      (mdc),
      .rise_evt (rise_evt),
      .fall_evt (fall_evt)
   );

   mdio_ue_shifter #(.PRE_LEN(PRE_LEN)) u_shifter (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en_q),
      .start    (start),
      .req      (req_q),
      .rise_evt (rise_evt),
      .fall_evt (fall_evt),
      .mdio_i   (mdio_i),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe),
      .busy     (sh_busy),
      .done     (sh_done),
      .ack      (sh_ack),
      .rdata    (sh_rdata)
   );

   AST_GO_CLEARS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(go_q) |-> $past(sh_done)); // R6

   AST_BUSY_HOLDS_GO: assert property (@(posedge clk) disable iff (!rst_n)
      sh_busy |-> go_q); // R6

   AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && go_q && !sh_done) |=> ($stable(req_q) && go_q)); // R7

   AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && $past(!en_q)) |-> (!sh_busy && !mdc)); // R10

   AST_MDC_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !sh_busy |=> !mdc); // R10

   AST_WRITE_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_done && req_q.wr) |=> !ack_q); // R11

endmodule

// File: tb/tb_mdio_user_engine.sv
`timescale 1ns/1ps
module tb_mdio_user_engine;

   localparam logic [4:0] PHY_ADDR = 5'd3;

   typedef struct packed {
      logic        wr;
      logic [4:0]  phy;
      logic [4:0]  rg;
      logic [15:0] data;
      logic        ack;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_sel = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] ctrl_rdata;
   logic [31:0] acc_rdata;
   logic        mdc;
   logic        mdio_o;
   logic        mdio_oe;
   logic        mdio_i;

   logic        phy_drv = 1'b0;
   logic        phy_bit = 1'b1;
   assign mdio_i = phy_drv ? phy_bit : 1'b1;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   exp_t        expq[$];
   logic [15:0] phy_regs [32];
   logic [15:0] mirror   [32];

   always #2.5 clk = ~clk;

   mdio_user_engine dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_sel    (reg_sel),
      .reg_wdata  (reg_wdata),
      .ctrl_rdata (ctrl_rdata),
      .acc_rdata  (acc_rdata),
      .mdc        (mdc),
      .mdio_o     (mdio_o),
      .mdio_oe    (mdio_oe),
      .mdio_i     (mdio_i)
   );

   function automatic logic [15:0] init_val(int r);
      return 16'hA5C3 ^ 16'(r * 16'h0101);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // ---------------- PHY model on the far side of the bus ----------------
   int          rcnt = 0;
   logic        prev_mdc = 1'b0;
   logic [63:0] cap = '0;
   logic [63:0] last_frame = '0;
   bit          oe_err = 0;
   bit          last_oe_err = 0;
   logic [1:0]  f_op = '0;
   logic [4:0]  f_phy = '0;
   logic [4:0]  f_reg = '0;

   always @(negedge clk) begin
      if (mdc && !prev_mdc) begin
         cap = {cap[62:0], mdio_o};
         if (rcnt < 46) begin
            if (!mdio_oe) oe_err = 1;
         end else if (f_op == 2'b10) begin
            if (mdio_oe) oe_err = 1;
         end else begin
            if (!mdio_oe) oe_err = 1;
         end
         if (rcnt == 45) begin
            f_op  = cap[11:10];
            f_phy = cap[9:5];
            f_reg = cap[4:0];
         end
         rcnt++;
      end
      if (!mdc && prev_mdc) begin
         if (rcnt == 64) begin
            last_frame  = cap;
            last_oe_err = oe_err;
            oe_err      = 0;
            if (cap[29:28] == 2'b01 && cap[27:23] == PHY_ADDR)
               phy_regs[cap[22:18]] = cap[15:0];
            phy_drv = 1'b0;
         end else if (f_op == 2'b10 && f_phy == PHY_ADDR && rcnt >= 47 && rcnt <= 63) begin
            phy_drv = 1'b1;
            phy_bit = (rcnt == 47) ? 1'b0 : phy_regs[f_reg][4'(63 - rcnt)];
         end else begin
            phy_drv = 1'b0;
         end
      end
      if (!rst_n || ctrl_rdata[31]) begin
         rcnt    = 0;
         phy_drv = 1'b0;
         oe_err  = 0;
         f_op    = '0;
      end
      prev_mdc = mdc;
   end

   // ---------------- monitor: pops expectations as frames complete ----------------
   logic prev_go = 1'b0;
   always @(negedge clk) begin
      logic [31:0] snap;
      exp_t        e;
      if (rst_n && prev_go && !acc_rdata[31]) begin
         snap = acc_rdata;
         @(negedge clk);
         if (expq.size() == 0) begin
            chk(0, "R6 unexpected completion", snap, 0);
         end else begin
            e = expq.pop_front();
            chk(last_frame[63:32] == 32'hFFFF_FFFF && last_frame[31:30] == 2'b01,
                "R3 preamble/start", last_frame[63:30], 34'h3_FFFF_FFFD);
            chk(last_frame[29:28] == (e.wr ? 2'b01 : 2'b10), "R3 opcode",
                last_frame[29:28], e.wr ? 2'b01 : 2'b10);
            chk(last_frame[27:18] == {e.phy, e.rg}, "R3 addresses",
                last_frame[27:18], {e.phy, e.rg});
            chk(!last_oe_err, e.wr ? "R4 oe pattern" : "R5 oe pattern", last_oe_err, 0);
            chk(snap[29] == e.ack, e.wr ? "R11 ack after write" : "R5 ack", snap[29], e.ack);
            if (e.wr) begin
               chk(last_frame[17:0] == {2'b10, e.data}, "R4 ta/data",
                   last_frame[17:0], {2'b10, e.data});
            end else if (e.ack) begin
               chk(snap[15:0] == e.data, "R5 read data", snap[15:0], e.data);
            end
         end
         prev_go = acc_rdata[31];
      end else begin
         prev_go = acc_rdata[31];
      end
   end

   // ---------------- driver ----------------
   task automatic bus_wr(input logic sel, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic set_ctrl(input logic en, input logic [15:0] div);
      bus_wr(1'b0, {1'b0, en, 14'd0, div});
   endtask

   task automatic wait_go_low();
      while (acc_rdata[31]) @(negedge clk);
   endtask

   task automatic issue(input logic wr, input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
      exp_t e;
      wait_go_low();
      e.wr = wr; e.phy = phy; e.rg = rg;
      if (wr) begin
         e.data = d; e.ack = 1'b0;
         if (phy == PHY_ADDR) mirror[rg] = d;
      end else begin
         e.data = mirror[rg]; e.ack = (phy == PHY_ADDR);
      end
      expq.push_back(e);
      bus_wr(1'b1, {1'b1, wr, 1'b0, 3'd0, rg, phy, wr ? d : 16'h0});
   endtask

   task automatic finish_frame();
      wait_go_low();
      repeat (4) @(negedge clk);
   endtask

   task automatic measure_mdc(input int exp_per, input int exp_hi, input string tag);
      logic p;
      int n, h;
      p = mdc;
      forever begin
         @(negedge clk);
         if (mdc && !p) break;
         p = mdc;
      end
      n = 0; h = 1; p = 1'b1;
      forever begin
         @(negedge clk);
         n++;
         if (mdc && !p) break;
         if (mdc) h++;
         p = mdc;
      end
      chk(n == exp_per, {tag, " period"}, n, exp_per);
      chk(h == exp_hi, {tag, " high time"}, h, exp_hi);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      bit saw_rise;
      for (int i = 0; i < 32; i++) begin
         phy_regs[i] = init_val(i);
         mirror[i]   = init_val(i);
      end
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(acc_rdata == 32'h0, "R1 access word", acc_rdata, 0);
      chk(ctrl_rdata == 32'h8000_0000, "R1 control word", ctrl_rdata, 32'h8000_0000);
      chk(!mdc && !mdio_oe, "R1 bus idle", {mdc, mdio_oe}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      set_ctrl(1'b1, 16'd3);
      chk(ctrl_rdata == 32'hC000_0003, "R6 control layout", ctrl_rdata, 32'hC000_0003);

      issue(1'b1, PHY_ADDR, 5'd4, 16'hBEEF);          // R4
      finish_frame();
      issue(1'b0, PHY_ADDR, 5'd4, 16'h0);             // R5 read back
      finish_frame();
      issue(1'b0, PHY_ADDR, 5'd9, 16'h0);             // R5 initial content
      finish_frame();
      issue(1'b1, PHY_ADDR, 5'd9, 16'h1234);          // R11 ack cleared after write
      finish_frame();
      issue(1'b0, 5'd7, 5'd1, 16'h0);                 // R5 absent PHY -> no ack
      finish_frame();

      // R6: go held and idle low while running
      issue(1'b0, PHY_ADDR, 5'd1, 16'h0);
      repeat (20) @(negedge clk);
      chk(acc_rdata[31] == 1'b1, "R6 go held", acc_rdata[31], 1);
      chk(ctrl_rdata[31] == 1'b0, "R6 idle low", ctrl_rdata[31], 0);
      finish_frame();

      // R2: clock divisor variants
      set_ctrl(1'b1, 16'd4);
      issue(1'b1, PHY_ADDR, 5'd10, 16'h0F0F);
      measure_mdc(5, 2, "R2 div4");
      finish_frame();
      set_ctrl(1'b1, 16'd0);
      issue(1'b0, PHY_ADDR, 5'd10, 16'h0);
      measure_mdc(2, 1, "R2 div0");
      finish_frame();
      set_ctrl(1'b1, 16'd7);
      issue(1'b0, PHY_ADDR, 5'd11, 16'h0);
      measure_mdc(8, 4, "R2 div7");
      finish_frame();
      set_ctrl(1'b1, 16'd3);

      // R7: access write while busy ignored
      issue(1'b0, PHY_ADDR, 5'd2, 16'h0);
      repeat (40) @(negedge clk);
      bus_wr(1'b1, {1'b1, 1'b1, 1'b0, 3'd0, 5'd2, PHY_ADDR, 16'hDEAD});
      finish_frame();
      chk(acc_rdata[30] == 1'b0 && acc_rdata[25:16] == {5'd2, PHY_ADDR},
          "R7 fields kept", acc_rdata[30:16], {1'b0, 4'd0, 5'd2, PHY_ADDR});
      saw_rise = 0;
      repeat (40) begin @(negedge clk); if (mdc) saw_rise = 1; end
      chk(!saw_rise && !acc_rdata[31], "R7 no extra frame", saw_rise, 0);
      issue(1'b0, PHY_ADDR, 5'd2, 16'h0);             // R7 PHY register untouched
      finish_frame();

      // R8: go 0 stores fields only
      bus_wr(1'b1, {1'b0, 1'b1, 1'b0, 3'd0, 5'd5, PHY_ADDR, 16'h5A5A});
      chk(acc_rdata == {1'b0, 1'b1, 1'b0, 3'd0, 5'd5, PHY_ADDR, 16'h5A5A}, "R8 stored word",
          acc_rdata, {1'b0, 1'b1, 1'b0, 3'd0, 5'd5, PHY_ADDR, 16'h5A5A});
      saw_rise = 0;
      repeat (30) begin @(negedge clk); if (mdc || !ctrl_rdata[31]) saw_rise = 1; end
      chk(!saw_rise, "R8 no frame", saw_rise, 0);

      // R9: pending while disabled
      set_ctrl(1'b0, 16'd3);
      issue(1'b1, PHY_ADDR, 5'd6, 16'h0F0F);
      saw_rise = 0;
      repeat (30) begin @(negedge clk); if (mdc || !ctrl_rdata[31]) saw_rise = 1; end
      chk(!saw_rise && acc_rdata[31], "R9 pending idle", {saw_rise, acc_rdata[31]}, 1);
      set_ctrl(1'b1, 16'd3);
      finish_frame();
      issue(1'b0, PHY_ADDR, 5'd6, 16'h0);             // R9 write landed
      finish_frame();

      // R10: disable mid-frame, then rerun
      issue(1'b0, PHY_ADDR, 5'd6, 16'h0);
      repeat (100) @(negedge clk);
      set_ctrl(1'b0, 16'd3);
      repeat (2) @(negedge clk);
      chk(ctrl_rdata[31] && !mdc && !mdio_oe && acc_rdata[31], "R10 stopped",
          {ctrl_rdata[31], mdc, mdio_oe, acc_rdata[31]}, 4'b1001);
      repeat (10) @(negedge clk);
      chk(!mdc && acc_rdata[31], "R10 stays stopped", {mdc, acc_rdata[31]}, 2'b01);
      set_ctrl(1'b1, 16'd3);
      finish_frame();

      repeat (10) @(negedge clk);
      chk(expq.size() == 0, "R6 all frames completed", expq.size(), 0);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule